// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Pin-Mode Decoding

This block models a byte-wide, one-time-programmable memory as a piece of synchronous logic. It looks at five control levels (chip select, output gate, program strobe, a flag that says the programming supply is raised, and a flag that says a high voltage sits on the identifier address line). From these it decides whether the part is idle, drives stored data, accepts a write, checks a write, or returns one of two fixed identifier bytes. The byte output is tri-state. It is modelled as a value plus a drive-enable, so the surrounding logic owns the actual bus.

A write can only clear bits. The cell takes the AND of its old contents and the presented byte. The only way back to all ones is the test-only erase sweep, which also runs by itself after reset so that the array starts blank. The sweep rewrites one location per clock and holds a busy flag high until the last location is done. The address width is a parameter: 17 bits gives the full 131072-location organisation. The default is kept small so that a plain elaboration stays light.

All controls are plain level pins. There is no valid/ready handshake, because the memory never applies back-pressure. A read result follows its address and control pins combinationally. A write takes effect at the clock edge that first samples the strobe low.

Top module: `otp_byte_rom`

## Requirements
- R1: While `ce_n` is 1, `dout_en` is 0 whatever `oe_n`, `pgm_n`, `vpp_hi` and `sig_hv` are.
- R2: With `ce_n`=0 and `oe_n`=1, `dout_en` is 0. With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `sig_hv`=0, `dout_en` is 1 and `dout` is the byte stored at `addr`.
- R3: A location changes only through a write. A write needs `ce_n`=0, `oe_n`=1 and `vpp_hi`=1 at a clock edge where `pgm_n` is sampled 0 after being sampled 1 at the previous edge. Any other combination leaves the array unchanged.
- R4: In the check mode (`ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=1, `sig_hv`=0), `dout_en` is 1 and `dout` is the stored byte.
- R5: A write stores the old byte ANDed with `din`, so a 0 bit never returns to 1 through a write.
- R6: A location that has not been written since the last erase reads 0xFF.
- R7: A write happens only once for each high-to-low transition of the sampled strobe. Holding `pgm_n` low causes no further write, even if `din` changes during the hold.
- R8: With `ce_n`=0, `oe_n`=0 and `sig_hv`=1, `dout_en` is 1 and `dout` is 0x20 when `addr[0]`=0 and 0x05 when `addr[0]`=1. This takes priority over the read and check modes.
- R9: With `ce_n`=0, `oe_n`=0, `pgm_n`=0, `vpp_hi`=1 and `sig_hv`=0, the mode is a conflict. `dout_en` is 0 and no write happens.
- R10: A 1 on `erase_all` while idle, and also the release of reset, starts a sweep. The sweep sets one location to 0xFF per clock. `erase_busy` stays 1 for exactly 2^ADDR_W clock edges and then falls, and every location then reads 0xFF.
- R11: While `erase_busy` is 1, program operations have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; on release it starts the blanking sweep |
| addr | input | ADDR_W | Location address; bit 0 selects the identifier byte |
| din | input | DATA_W | Byte to be written |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low, edge-sampled on clk |
| vpp_hi | input | 1 | Programming supply raised |
| sig_hv | input | 1 | High voltage present on the identifier address line |
| erase_all | input | 1 | Test-only request to blank the whole array |
| dout | output | DATA_W | Output byte value |
| dout_en | output | 1 | Output drive-enable; 0 means high impedance |
| erase_busy | output | 1 | Sweep in progress |

## Verification
The bench builds the block with ADDR_W=6, so the array has 64 locations. At that size a blanking sweep takes only 64 cycles. The bench can therefore time a whole sweep edge by edge and still fire a program attempt in the middle of one. Both identifier bytes and a spread of ordinary locations fall in the same small address space. This lets the bench cover the mode priorities, the bit-clearing write and the once-per-strobe rule in a short run.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_INHIBIT,
    M_OUTOFF,
    M_READ,
    M_PROG,
    M_VERIFY,
    M_IDENT,
    M_CLASH
  } rom_mode_e;

  localparam logic [7:0] MAKER_ID = 8'h20;
  localparam logic [7:0] PART_ID  = 8'h05;

  function automatic logic mode_drives(rom_mode_e m);
    return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_rom_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      vpp_hi,
  input  logic      sig_hv,
  output rom_mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    end else if (oe_n) begin
      mode = vpp_hi ? M_PROG : M_OUTOFF;
    end else if (sig_hv) begin
      mode = M_IDENT;
    end else if (vpp_hi) begin
      mode = pgm_n ? M_VERIFY : M_CLASH;
    end else begin
      mode = M_READ;
    end
  end

endmodule

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  output logic fall
);

  logic pgm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;
  end

  assign fall = pgm_q & ~pgm_n;

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] wr_old;

  assign wr_old  = mem[wa];
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) busy <= 1'b0;
      ptr <= ptr + 1'b1;
    end else if (erase_req) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy)    mem[ptr] <= '1;
    else if (we) mem[wa]  <= wr_old & wd;
  end

  // R5: a write leaves old AND new data
  a_r5_and_only: assert property (@(posedge clk) disable iff (!rst_n)
    we && !busy |=> mem[$past(wa)] == ($past(wr_old) & $past(wd)));

  // R11: no write strobe reaches the array during a sweep
  a_r11_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !we);

  // R10: the sweep ends only after the last location
  a_r10_sweep_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ptr) == LAST);

endmodule

// File: rtl/otp_byte_rom.sv
module otp_byte_rom
  import otp_rom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              sig_hv,
  input  logic              erase_all,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              erase_busy
);

  rom_mode_e         mode;
  logic              fall;
  logic              wr_fire;
  logic [DATA_W-1:0] cell_q;
  logic [DATA_W-1:0] id_byte;

  otp_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .sig_hv (sig_hv),
    .mode   (mode)
  );

  otp_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pgm_n (pgm_n),
    .fall  (fall)
  );

  assign wr_fire = fall && (mode == M_PROG) && !erase_busy;

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_req (erase_all),
    .rd_addr   (addr),
    .rd_data   (cell_q),
    .we        (wr_fire),
    .wa        (addr),
    .wd        (din),
    .busy      (erase_busy)
  );

  assign id_byte = addr[0] ? DATA_W'(PART_ID) : DATA_W'(MAKER_ID);
  assign dout    = (mode == M_IDENT) ? id_byte : cell_q;
  assign dout_en = mode_drives(mode);

  // R1: deselected part never drives
  a_r1_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);

  // R2: gate high keeps the bus free
  a_r2_gate_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n && oe_n |-> !dout_en);

  // R7: a write needs the strobe high at the previous edge
  a_r7_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(pgm_n));

  // R8: identifier codes
  a_r8_ident_code: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n && !oe_n && sig_hv |-> dout_en &&
      (dout == (addr[0] ? DATA_W'(8'h05) : DATA_W'(8'h20))));

  // R9: conflicting controls neither drive nor write
  a_r9_clash_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n && !oe_n && !pgm_n && vpp_hi && !sig_hv |-> !dout_en && !wr_fire);

endmodule

// File: tb/tb_otp_byte_rom.sv
module tb_otp_byte_rom;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'hFF;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, sig_hv = 1'b0;
  logic erase_all = 1'b0;
  logic [7:0] dout;
  logic dout_en, erase_busy;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  otp_byte_rom #(.ADDR_W(AW), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .sig_hv(sig_hv), .erase_all(erase_all),
    .dout(dout), .dout_en(dout_en), .erase_busy(erase_busy)
  );

  typedef struct packed {
    logic       prog;
    logic       ce_n, oe_n, pgm_n, vpp, sig;
    logic [5:0] a;
    logic [7:0] d;
    logic       en;
    logic [7:0] q;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'hFF, 4'd6},  // R6 blank
    '{1'b1, 1'b0,1'b1,1'b1,1'b1,1'b0, 6'd5,  8'hA5, 1'b0, 8'h00, 4'd5},
    '{1'b0, 1'b0,1'b0,1'b1,1'b1,1'b0, 6'd5,  8'h00, 1'b1, 8'hA5, 4'd4},  // R4 check mode
    '{1'b1, 1'b0,1'b1,1'b1,1'b1,1'b0, 6'd5,  8'h3C, 1'b0, 8'h00, 4'd5},
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24, 4'd5},  // R5 AND
    '{1'b1, 1'b0,1'b1,1'b1,1'b1,1'b0, 6'd5,  8'hFF, 1'b0, 8'h00, 4'd5},
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24, 4'd5},  // R5 no set
    '{1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0, 6'd5,  8'h00, 1'b0, 8'h00, 4'd2},  // R2 gate off
    '{1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0, 6'd5,  8'h00, 1'b0, 8'h00, 4'd1},  // R1 standby
    '{1'b0, 1'b1,1'b0,1'b1,1'b1,1'b0, 6'd5,  8'h00, 1'b0, 8'h00, 4'd1},  // R1 inhibit
    '{1'b0, 1'b1,1'b0,1'b1,1'b0,1'b1, 6'd5,  8'h00, 1'b0, 8'h00, 4'd1},  // R1 sig ignored
    '{1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0, 6'd5,  8'h00, 1'b0, 8'h00, 4'd9},  // R9 clash
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b1, 6'd0,  8'h00, 1'b1, 8'h20, 4'd8},  // R8 maker
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b1, 6'd1,  8'h00, 1'b1, 8'h05, 4'd8},  // R8 part
    '{1'b0, 1'b0,1'b0,1'b1,1'b1,1'b1, 6'd5,  8'h00, 1'b1, 8'h05, 4'd8},  // R8 over check
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b1, 6'd4,  8'h00, 1'b1, 8'h20, 4'd8},  // R8 bit0 only
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 6'd9,  8'h00, 1'b1, 8'hFF, 4'd6},  // R6 other loc
    '{1'b1, 1'b1,1'b1,1'b1,1'b1,1'b0, 6'd7,  8'h00, 1'b0, 8'h00, 4'd3},
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 6'd7,  8'h00, 1'b1, 8'hFF, 4'd3},  // R3 inhibit
    '{1'b1, 1'b0,1'b1,1'b1,1'b0,1'b0, 6'd8,  8'h00, 1'b0, 8'h00, 4'd3},
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 6'd8,  8'h00, 1'b1, 8'hFF, 4'd3},  // R3 no supply
    '{1'b1, 1'b0,1'b0,1'b1,1'b1,1'b0, 6'd10, 8'h00, 1'b0, 8'h00, 4'd9},
    '{1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0, 6'd10, 8'h00, 1'b1, 8'hFF, 4'd9},  // R9 no write
    '{1'b1, 1'b0,1'b1,1'b1,1'b1,1'b0, 6'd12, 8'h0F, 1'b0, 8'h00, 4'd3},
    '{1'b0, 1'b0,1'b0,1'b1,1'b1,1'b0, 6'd12, 8'h00, 1'b1, 8'h0F, 4'd3}   // R3 legal write
  };

  task automatic check(input string req, input logic en_exp, input logic [7:0] q_exp);
    checks++;
    if (dout_en !== en_exp || (en_exp && dout !== q_exp)) begin
      failures++;
      $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
               req, dout_en, dout, en_exp, q_exp);
    end
  endtask

  task automatic set_pins(input logic c, input logic o, input logic p, input logic v,
                          input logic s, input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; sig_hv = s; addr = a; din = d;
  endtask

  task automatic pulse_prog(input logic c, input logic o, input logic v,
                            input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    set_pins(c, o, 1'b1, v, 1'b0, a, d);
    @(negedge clk);
    pgm_n = 1'b0;
    repeat (3) @(negedge clk);
    pgm_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_at(input logic [AW-1:0] a);
    @(negedge clk);
    set_pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00);
    #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state: deselected, no drive
    #2;
    check("R1 reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    // R10 sweep after reset
    checks++;
    if (erase_busy !== 1'b1) begin
      failures++;
      $display("FAIL R10 reset sweep: erase_busy=%0b expected 1", erase_busy);
    end
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (erase_busy && cnt < 1000);
    checks++;
    if (cnt != DEPTH) begin
      failures++;
      $display("FAIL R10 reset sweep length: %0d expected %0d", cnt, DEPTH);
    end

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].prog) begin
        pulse_prog(VECS[i].ce_n, VECS[i].oe_n, VECS[i].vpp, AW'(VECS[i].a), VECS[i].d);
      end else begin
        @(negedge clk);
        set_pins(VECS[i].ce_n, VECS[i].oe_n, VECS[i].pgm_n, VECS[i].vpp, VECS[i].sig,
                 AW'(VECS[i].a), VECS[i].d);
        #2;
        check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].en, VECS[i].q);
      end
    end

    // R7: strobe held low, data changed during the hold
    @(negedge clk);
    set_pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(20), 8'hF0);
    @(negedge clk);
    pgm_n = 1'b0;
    repeat (2) @(negedge clk);
    din = 8'h0F;
    repeat (4) @(negedge clk);
    pgm_n = 1'b1;
    read_at(AW'(20));
    check("R7 single write", 1'b1, 8'hF0);

    // R10: requested sweep, timed
    @(negedge clk);
    set_pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 8'hFF);
    erase_all = 1'b1;
    @(negedge clk);
    erase_all = 1'b0;
    cnt = 0;
    while (erase_busy && cnt < 1000) begin @(negedge clk); cnt++; end
    checks++;
    if (cnt != DEPTH) begin
      failures++;
      $display("FAIL R10 erase length: %0d expected %0d", cnt, DEPTH);
    end
    read_at(AW'(5));
    check("R10 erased 5", 1'b1, 8'hFF);
    read_at(AW'(12));
    check("R10 erased 12", 1'b1, 8'hFF);

    // R11: write attempt after the sweep has passed location 0
    @(negedge clk);
    erase_all = 1'b1;
    @(negedge clk);
    erase_all = 1'b0;
    repeat (10) @(negedge clk);
    pulse_prog(1'b0, 1'b1, 1'b1, AW'(0), 8'h00);
    checks++;
    if (erase_busy !== 1'b1) begin
      failures++;
      $display("FAIL R11 busy during attempt: erase_busy=%0b expected 1", erase_busy);
    end
    cnt = 0;
    while (erase_busy && cnt < 1000) begin @(negedge clk); cnt++; end
    read_at(AW'(0));
    check("R11 write ignored while busy", 1'b1, 8'hFF);

    // R5: write after sweep clears bits again
    pulse_prog(1'b0, 1'b1, 1'b1, AW'(63), 8'h81);
    read_at(AW'(63));
    check("R5 top location", 1'b1, 8'h81);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule